// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Splitter and Command Decoder

This block sits between a 16-bit processor core model whose address and data share one set of lines and the external memory and I/O. While the core's address-latch-enable strobe is high, the block passes the 20-bit address through to a registered address output. When the strobe drops, the address is frozen, so it stays valid for the rest of the bus cycle after the shared lines carry data. The data lines themselves are never latched.

The core's read strobe, write strobe and memory-versus-I/O select are turned into four active-low commands: memory read, memory write, I/O read and I/O write. The block also drives the enable and direction of the external data transceiver. During the data phase the upper four address lines carry status. The block decodes which segment is in use, as a code and as a one-hot vector, and it also decodes the interrupt-enable state.

All outputs are registered. Each one follows its inputs one clock later. Every input is sampled synchronously to `clk`.

Top module: `muxbus_splitter`

## Requirements
- R1: While `ale` is high, `lat_addr` shows `{ad_hi, ad_lo}` one clock later.
- R2: While `ale` is low, `lat_addr` holds the value captured in the last cycle that `ale` was high, whatever the shared lines carry.
- R3: One clock after the inputs, exactly one command is low when exactly one strobe is active (`rd_n`=0 with `wr_n`=1, or `wr_n`=0 with `rd_n`=1). With `mem_io`=1 this is `mrd_n` or `mwr_n`; with `mem_io`=0 it is `iord_n` or `iowr_n`.
- R4: No more than one command is ever low. If `rd_n` and `wr_n` are both low, all four commands are high one clock later.
- R5: If `rd_n` and `wr_n` are both high, all four commands are high one clock later.
- R6: One clock after the inputs, `xcvr_oe_n` equals `den_n` and `xcvr_tx` equals `dt_r`. A value of 1 on `xcvr_tx` means core-to-bus (write); 0 means bus-to-core (read).
- R7: While `ale` is low, `seg_id` takes `ad_hi[1:0]` one clock later. The codes are 0 = extra, 1 = stack, 2 = code and 3 = data. `seg_hot` has exactly the bit at index `seg_id` set.
- R8: While `ale` is low, `int_en` takes `ad_hi[2]` one clock later. While `ale` is high, `seg_id`, `seg_hot` and `int_en` hold their values. `ad_hi[3]` has no effect on them.
- R9: While `rst_n` is low: `lat_addr`=0, all commands=1, `xcvr_oe_n`=1, `xcvr_tx`=0, `seg_id`=0, `seg_hot`=4'b0001, `int_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_lo | input | 16 | Shared low address/data lines |
| ad_hi | input | 4 | Upper address lines, carrying status in the data phase |
| ale | input | 1 | Address latch enable strobe |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| mem_io | input | 1 | 1 = memory access, 0 = I/O access |
| dt_r | input | 1 | Transfer direction, 1 = transmit |
| den_n | input | 1 | Active-low data enable |
| lat_addr | output | 20 | Latched address |
| seg_id | output | 2 | Decoded segment code |
| seg_hot | output | 4 | One-hot segment |
| int_en | output | 1 | Decoded interrupt-enable status |
| mrd_n | output | 1 | Memory read command |
| mwr_n | output | 1 | Memory write command |
| iord_n | output | 1 | I/O read command |
| iowr_n | output | 1 | I/O write command |
| xcvr_oe_n | output | 1 | Transceiver enable, active low |
| xcvr_tx | output | 1 | Transceiver direction |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it: the address, the commands, the transceiver controls and the decoded status. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which is half a period after the single rising edge that registers them. Hold behaviour is checked at that same sampling point over several consecutive cycles while the inputs keep changing. The bench sweeps all 32 strobe/select/enable combinations and all 16 upper-line status values.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
    typedef enum logic [1:0] {
        SEG_EXTRA = 2'd0,
        SEG_STACK = 2'd1,
        SEG_CODE  = 2'd2,
        SEG_DATA  = 2'd3
    } seg_e;

    typedef struct packed {
        logic mrd_n;
        logic mwr_n;
        logic iord_n;
        logic iowr_n;
        logic oe_n;
        logic tx;
    } bus_ctl_t;

    localparam bus_ctl_t BUS_CTL_IDLE = '{mrd_n: 1'b1, mwr_n: 1'b1,
                                          iord_n: 1'b1, iowr_n: 1'b1,
                                          oe_n: 1'b1, tx: 1'b0};
endpackage

// File: rtl/muxbus_addr_latch.sv
module muxbus_addr_latch #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [DATA_W-1:0] ad_lo,
    input  logic [HI_W-1:0]   ad_hi,
    output logic [ADDR_W-1:0] addr_q
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } latch_st_t;

    latch_st_t st_d, st_q;

    // Pass-through while the strobe is high; freeze after it falls.
    always_comb begin
        st_d = st_q;
        if (ale) begin
            st_d.addr = {ad_hi, ad_lo};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q = st_q.addr;

    assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (addr_q == $past({ad_hi, ad_lo})));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(addr_q));
endmodule

// File: rtl/muxbus_cmd_decode.sv
module muxbus_cmd_decode
    import muxbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_n,
    input  logic     wr_n,
    input  logic     mem_io,
    input  logic     dt_r,
    input  logic     den_n,
    output bus_ctl_t ctl_q
);
    bus_ctl_t ctl_d, ctl_r;

    always_comb begin
        ctl_d = BUS_CTL_IDLE;
        // Exactly one strobe active selects exactly one command.
        if (!rd_n && wr_n) begin
            if (mem_io) ctl_d.mrd_n  = 1'b0;
            else        ctl_d.iord_n = 1'b0;
        end else if (rd_n && !wr_n) begin
            if (mem_io) ctl_d.mwr_n  = 1'b0;
            else        ctl_d.iowr_n = 1'b0;
        end
        ctl_d.oe_n = den_n;
        ctl_d.tx   = dt_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r <= BUS_CTL_IDLE;
        end else begin
            ctl_r <= ctl_d;
        end
    end

    assign ctl_q = ctl_r;

    assert_one_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ctl_r.mrd_n, ~ctl_r.mwr_n, ~ctl_r.iord_n, ~ctl_r.iowr_n}) <= 1);

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n && wr_n) |=> (ctl_r.mrd_n && ctl_r.mwr_n && ctl_r.iord_n && ctl_r.iowr_n));

    assert_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && wr_n && mem_io) |=> !ctl_r.mrd_n);

    assert_xcvr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        den_n |=> ctl_r.oe_n);
endmodule

// File: rtl/muxbus_status_decode.sv
module muxbus_status_decode #(
    parameter int HI_W  = 4,
    parameter int SEG_W = 2,
    localparam int NSEG = 1 << SEG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale,
    input  logic [HI_W-1:0]  ad_hi,
    output logic [SEG_W-1:0] seg_q,
    output logic [NSEG-1:0]  hot_q,
    output logic             ie_q
);
    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [NSEG-1:0]  hot;
        logic             ie;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [NSEG-1:0] hot_next;

    for (genvar i = 0; i < NSEG; i++) begin : g_hot
        assign hot_next[i] = (ad_hi[SEG_W-1:0] == SEG_W'(i));
    end

    // Status occupies the upper lines only outside the address phase.
    always_comb begin
        st_d = st_q;
        if (!ale) begin
            st_d.seg = ad_hi[SEG_W-1:0];
            st_d.hot = hot_next;
            st_d.ie  = ad_hi[SEG_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.hot <= NSEG'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_q = st_q.seg;
    assign hot_q = st_q.hot;
    assign ie_q  = st_q.ie;

    assert_hot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hot_q) == 1);

    assert_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> (seg_q == $past(ad_hi[SEG_W-1:0])));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> ($stable(seg_q) && $stable(ie_q) && $stable(hot_q)));
endmodule

// File: rtl/muxbus_splitter.sv
module muxbus_splitter
    import muxbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int SEG_W  = 2,
    localparam int HI_W  = ADDR_W - DATA_W,
    localparam int NSEG  = 1 << SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ad_lo,
    input  logic [HI_W-1:0]   ad_hi,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              mem_io,
    input  logic              dt_r,
    input  logic              den_n,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [SEG_W-1:0]  seg_id,
    output logic [NSEG-1:0]   seg_hot,
    output logic              int_en,
    output logic              mrd_n,
    output logic              mwr_n,
    output logic              iord_n,
    output logic              iowr_n,
    output logic              xcvr_oe_n,
    output logic              xcvr_tx
);
    bus_ctl_t ctl;

    muxbus_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_latch (
        .clk(clk), .rst_n(rst_n), .ale(ale),
        .ad_lo(ad_lo), .ad_hi(ad_hi), .addr_q(lat_addr)
    );

    muxbus_cmd_decode i_cmd (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
        .mem_io(mem_io), .dt_r(dt_r), .den_n(den_n), .ctl_q(ctl)
    );

    muxbus_status_decode #(.HI_W(HI_W), .SEG_W(SEG_W)) i_stat (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_hi(ad_hi),
        .seg_q(seg_id), .hot_q(seg_hot), .ie_q(int_en)
    );

    assign mrd_n     = ctl.mrd_n;
    assign mwr_n     = ctl.mwr_n;
    assign iord_n    = ctl.iord_n;
    assign iowr_n    = ctl.iowr_n;
    assign xcvr_oe_n = ctl.oe_n;
    assign xcvr_tx   = ctl.tx;

    assert_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (xcvr_tx == $past(dt_r)));
endmodule

// File: tb/test_muxbus_splitter.sv
`timescale 1ns/1ps
module test_muxbus_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ad_lo = '0;
    logic [3:0]  ad_hi = '0;
    logic        ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic        mem_io = 1'b0, dt_r = 1'b0, den_n = 1'b1;
    logic [19:0] lat_addr;
    logic [1:0]  seg_id;
    logic [3:0]  seg_hot;
    logic        int_en, mrd_n, mwr_n, iord_n, iowr_n, xcvr_oe_n, xcvr_tx;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    muxbus_splitter i_muxbus_splitter (
        .clk(clk), .rst_n(rst_n), .ad_lo(ad_lo), .ad_hi(ad_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .mem_io(mem_io), .dt_r(dt_r), .den_n(den_n),
        .lat_addr(lat_addr), .seg_id(seg_id), .seg_hot(seg_hot), .int_en(int_en),
        .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .xcvr_oe_n(xcvr_oe_n), .xcvr_tx(xcvr_tx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply on falling edge, one rising edge registers, sample on next falling edge.
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        logic [19:0] held;
        logic [19:0] pats [8];
        pats = '{20'h00000, 20'hFFFFF, 20'hA5A5A, 20'h5A5A5,
                 20'h12345, 20'hF0001, 20'h0FFFE, 20'h80000};
        @(negedge clk);
        ad_lo = 16'hBEEF; ad_hi = 4'hF; ale = 1'b1; rd_n = 1'b0; den_n = 1'b0; dt_r = 1'b1;
        repeat (3) step();
        // R9 reset state
        check("R9 addr", 32'(lat_addr), 32'h0);
        check("R9 cmds", 32'({mrd_n, mwr_n, iord_n, iowr_n}), 32'hF);
        check("R9 xcvr", 32'({xcvr_oe_n, xcvr_tx}), 32'h2);
        check("R9 status", 32'({seg_id, seg_hot, int_en}), 32'({2'd0, 4'b0001, 1'b0}));
        rst_n = 1'b1; rd_n = 1'b1; den_n = 1'b1; dt_r = 1'b0; ale = 1'b0;
        step();

        // R1 / R2 address capture and hold
        foreach (pats[k]) begin
            ale = 1'b1; {ad_hi, ad_lo} = pats[k];
            step();
            check("R1 follow", 32'(lat_addr), 32'(pats[k]));
            held = pats[k];
            ale = 1'b0;
            for (int j = 0; j < 3; j++) begin
                {ad_hi, ad_lo} = ~held ^ 20'(j * 20'h1111);
                step();
                check("R2 hold", 32'(lat_addr), 32'(held));
            end
        end

        // R3 R4 R5 R6 command and transceiver sweep
        ale = 1'b0;
        for (int v = 0; v < 32; v++) begin
            logic [3:0] exp_cmd;
            logic [4:0] b;
            b = 5'(v);
            {mem_io, rd_n, wr_n, den_n, dt_r} = b;
            exp_cmd = 4'hF;  // order {mrd_n, mwr_n, iord_n, iowr_n}
            if (!b[3] && b[2])      exp_cmd = b[4] ? 4'b0111 : 4'b1101;
            else if (b[3] && !b[2]) exp_cmd = b[4] ? 4'b1011 : 4'b1110;
            step();
            if (b[3] == b[2]) check("R4 R5 idle", 32'({mrd_n, mwr_n, iord_n, iowr_n}), 32'(exp_cmd));
            else              check("R3 cmd", 32'({mrd_n, mwr_n, iord_n, iowr_n}), 32'(exp_cmd));
            check("R6 xcvr", 32'({xcvr_oe_n, xcvr_tx}), 32'({b[1], b[0]}));
        end
        rd_n = 1'b1; wr_n = 1'b1;

        // R7 R8 status sweep, all 16 upper-line values
        for (int v = 0; v < 16; v++) begin
            ale = 1'b0; ad_hi = 4'(v);
            step();
            check("R7 seg", 32'(seg_id), 32'(v % 4));
            check("R7 hot", 32'(seg_hot), 32'(1 << (v % 4)));
            check("R8 ie", 32'(int_en), 32'((v >> 2) & 1));
            // R8 hold while ale high
            ale = 1'b1; ad_hi = ~4'(v);
            step();
            check("R8 hold", 32'({seg_id, seg_hot, int_en}),
                  32'({2'(v % 4), 4'(1 << (v % 4)), 1'((v >> 2) & 1)}));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule